// File: doc/BRIEF.md
# Table-Encoded Programmable Clock Divider

This block produces a one-cycle enable strobe at a rate derived from its input clock. Logic downstream uses the strobe as a clock enable in place of a second clock. The rate is chosen by a small code field held in a configuration register. The code does not give the division ratio directly. It passes through a lookup that is non-uniform and saturating, and which lookup applies is chosen at build time by a profile parameter.

Three profiles are available. The bus profile has a 3-bit code giving ratios 1 to 4. The controller profile has a 4-bit code giving powers of two, with a saturating top band. The peripheral profile has a 3-bit code giving powers of two up to 16. Software writes the code and can read it back. The running ratio changes only when the current period ends, so no period is ever cut short.

Top module: `tbl_clk_div`

## Requirements
- R1: While the internal reset is active, and in the first cycle after it ends, the code reads back as 0 and the strobe is high on every cycle. Code 0 means divide-by 1.
- R2: In the bus profile (PROFILE=0, 3-bit code), codes 0, 1, 2 and 3 divide by 1, 2, 3 and 4. Codes 4 to 7 all divide by 4.
- R3: In the controller profile (PROFILE=1, 4-bit code), code k from 0 to 7 divides by 2^k. Codes 8 to 15 all divide by 512, so divide-by 256 never occurs.
- R4: In the peripheral profile (PROFILE=2, 3-bit code), codes 0 to 4 divide by 1, 2, 4, 8 and 16. Codes 5 to 7 all divide by 16.
- R5: With an active ratio N, the strobe is high for one cycle and then low for N-1 cycles. With N=1 it is high on every cycle.
- R6: A code written in the middle of a period does not change that period's length. The new ratio starts with the period that follows the next strobe.
- R7: A write made in the same cycle as a strobe takes effect for the period that starts right after that strobe.
- R8: The code sits at bits [CODE_W-1:0] of the write data and of the read-back word. The read-back holds the written code from the cycle after the write, and its upper bits read as zero.
- R9: Without a write, the read-back value does not change.
- R10: When several writes land inside one period, only the last code written before the boundary sets the next ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we_i | input | 1 | Write strobe for the code register |
| cfg_wdata_i | input | CODE_W | New divider code (3 bits, or 4 in the controller profile) |
| cfg_rdata_o | output | REG_W | Read-back of the programmed code, zero-extended |
| tick_o | output | 1 | One-cycle enable strobe at the divided rate |

## Verification
Two things can fall in the same cycle: a register write and the end of a period. When they do, the write must both update the read-back and set the ratio for the period that starts next. The bench provokes this by waiting at a falling edge until the strobe is high, then raising the write strobe in that same cycle. This is repeated for several codes and for all three profiles at once. A behavioural model tracks cycles since the last strobe and the pending code, and the design is judged against it on every clock. Any early, late or missing strobe, or a stale read-back, therefore shows up in the cycle where it happens.

// File: rtl/tcd_pkg.sv
package tcd_pkg;
  localparam int MAX_RATIO = 512;
  localparam int RATIO_W   = $clog2(MAX_RATIO + 1);

  // Division ratio per profile: 0 bus, 1 controller, 2 peripheral
  function automatic logic [RATIO_W-1:0] ratio_of(input int prof, input logic [3:0] code);
    logic [RATIO_W-1:0] r;
    case (prof)
      1:       r = code[3] ? RATIO_W'(MAX_RATIO) : RATIO_W'(1) << code[2:0];
      2:       r = (code > 4'd4) ? RATIO_W'(16) : RATIO_W'(1) << code[2:0];
      default: r = (code < 4'd4) ? RATIO_W'(code) + RATIO_W'(1) : RATIO_W'(4);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/tcd_rst_sync.sv
module tcd_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_no = stage_q[1];
endmodule

// File: rtl/tcd_code_reg.sv
module tcd_code_reg #(
  parameter int CODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CODE_W-1:0] wdata_i,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] code_q, code_d;

  always_comb begin
    code_d = code_q;
    if (we_i) code_d = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= '0;
    else         code_q <= code_d;
  end

  assign code_o = code_q;
endmodule

// File: rtl/tcd_ratio_lut.sv
module tcd_ratio_lut #(
  parameter int PROFILE = 0,
  parameter int CODE_W  = 3,
  localparam int RW     = tcd_pkg::RATIO_W
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [RW-1:0]     ratio_o
);
  logic [3:0] code_ext;
  assign code_ext = 4'(code_i);

  generate
    if (PROFILE == 1) begin : g_ctrl
      // Powers of two below bit 3, one saturated band above
      always_comb begin
        if (code_ext[3]) ratio_o = RW'(tcd_pkg::MAX_RATIO);
        else             ratio_o = RW'(1) << code_ext[2:0];
      end
    end else if (PROFILE == 2) begin : g_periph
      always_comb begin
        if (code_ext[2] && (code_ext[1:0] != 2'b00)) ratio_o = RW'(16);
        else                                         ratio_o = RW'(1) << code_ext[2:0];
      end
    end else begin : g_bus
      // Linear 1..4, then flat
      always_comb begin
        if (code_ext[2]) ratio_o = RW'(4);
        else             ratio_o = RW'(code_ext[1:0]) + RW'(1);
      end
    end
  endgenerate
endmodule

// File: rtl/tcd_period_ctr.sv
module tcd_period_ctr #(
  localparam int RW = tcd_pkg::RATIO_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [RW-1:0] ratio_next_i,
  output logic          tick_o,
  output logic [RW-1:0] ratio_o
);
  logic [RW-1:0] cnt_q, cnt_d;
  logic [RW-1:0] ratio_q, ratio_d;
  logic          last;

  always_comb begin
    last    = (cnt_q == RW'(ratio_q - RW'(1)));
    cnt_d   = last ? '0 : cnt_q + RW'(1);
    ratio_d = last ? ratio_next_i : ratio_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ratio_q <= RW'(1);
    end else begin
      cnt_q   <= cnt_d;
      ratio_q <= ratio_d;
    end
  end

  assign tick_o  = last;
  assign ratio_o = ratio_q;
endmodule

// File: rtl/tbl_clk_div.sv
module tbl_clk_div #(
  parameter int  PROFILE = 0,
  parameter int  REG_W   = 8,
  localparam int CODE_W  = (PROFILE == 1) ? 4 : 3,
  localparam int RW      = tcd_pkg::RATIO_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CODE_W-1:0] cfg_wdata_i,
  output logic [REG_W-1:0]  cfg_rdata_o,
  output logic              tick_o
);
  logic              rst_sync_n;
  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] lut_code;
  logic [RW-1:0]     ratio_next;
  logic [RW-1:0]     act_ratio;

  tcd_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  tcd_code_reg #(.CODE_W(CODE_W)) u_code (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .code_o  (code_q)
  );

  // A write in a boundary cycle feeds the lookup directly
  assign lut_code = cfg_we_i ? cfg_wdata_i : code_q;

  tcd_ratio_lut #(.PROFILE(PROFILE), .CODE_W(CODE_W)) u_lut (
    .code_i  (lut_code),
    .ratio_o (ratio_next)
  );

  tcd_period_ctr u_ctr (
    .clk_i        (clk_i),
    .rst_ni       (rst_sync_n),
    .ratio_next_i (ratio_next),
    .tick_o       (tick_o),
    .ratio_o      (act_ratio)
  );

  assign cfg_rdata_o = REG_W'(code_q);
endmodule

// File: rtl/tcd_chk.sv
module tcd_chk #(
  parameter int PROFILE = 0,
  parameter int CODE_W  = 3,
  parameter int REG_W   = 8,
  parameter int RW      = 10
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic              cfg_we_i,
  input logic [CODE_W-1:0] cfg_wdata_i,
  input logic [REG_W-1:0]  cfg_rdata_o,
  input logic              tick_o,
  input logic [RW-1:0]     ratio_i
);
  logic [RW-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)      gap_q <= '0;
    else if (tick_o) gap_q <= '0;
    else             gap_q <= gap_q + RW'(1);
  end

  // R5
  period_len_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    tick_o |-> (RW'(gap_q + RW'(1)) == ratio_i));

  // R5
  no_early_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !tick_o |-> (RW'(gap_q + RW'(1)) < ratio_i));

  // R6
  ratio_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !tick_o |=> $stable(ratio_i));

  // R7
  boundary_write_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (tick_o && cfg_we_i) |=> (ratio_i == tcd_pkg::ratio_of(PROFILE, 4'($past(cfg_wdata_i)))));

  // R8
  readback_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    cfg_we_i |=> (cfg_rdata_o == REG_W'($past(cfg_wdata_i))));

  // R9
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !cfg_we_i |=> $stable(cfg_rdata_o));

  // R3
  legal_ratio_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (ratio_i != '0) && (ratio_i <= RW'(tcd_pkg::MAX_RATIO)) && (ratio_i != RW'(256)));
endmodule

bind tbl_clk_div tcd_chk #(
  .PROFILE (PROFILE),
  .CODE_W  (CODE_W),
  .REG_W   (REG_W),
  .RW      (RW)
) u_chk (
  .clk_i       (clk_i),
  .rst_n       (rst_sync_n),
  .cfg_we_i    (cfg_we_i),
  .cfg_wdata_i (cfg_wdata_i),
  .cfg_rdata_o (cfg_rdata_o),
  .tick_o      (tick_o),
  .ratio_i     (act_ratio)
);

// File: tb/test_tbl_clk_div.sv
`timescale 1ns/1ps
module test_tbl_clk_div;
  logic       clk;
  logic       rst_n;
  logic       we;
  logic [3:0] wdata;
  logic [2:0] tick;
  logic [7:0] rdata [3];

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  // Behavioural reference state per profile
  int m_code  [3];
  int m_ratio [3];
  int m_cnt   [3];
  int sync_cnt;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  tbl_clk_div #(.PROFILE(0), .REG_W(8)) i_tbl_clk_div (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_wdata_i(wdata[2:0]),
    .cfg_rdata_o(rdata[0]), .tick_o(tick[0]));
  tbl_clk_div #(.PROFILE(1), .REG_W(8)) i_tbl_clk_div_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_wdata_i(wdata),
    .cfg_rdata_o(rdata[1]), .tick_o(tick[1]));
  tbl_clk_div #(.PROFILE(2), .REG_W(8)) i_tbl_clk_div_per (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_wdata_i(wdata[2:0]),
    .cfg_rdata_o(rdata[2]), .tick_o(tick[2]));

  function automatic int code_mask(input int p);
    return (p == 1) ? 15 : 7;
  endfunction

  // R2 R3 R4: ratio taken from the requirement text
  function automatic int exp_ratio(input int p, input int c);
    if (p == 0) return (c <= 3) ? c + 1 : 4;
    if (p == 1) return (c <= 7) ? (1 << c) : 512;
    return (c <= 4) ? (1 << c) : 16;
  endfunction

  function automatic string prof_tags(input int p);
    if (p == 0) return "R2 R5 R6 R7 R10";
    if (p == 1) return "R3 R5 R6 R7 R10";
    return "R4 R5 R6 R7 R10";
  endfunction

  task automatic model_reset();
    for (int p = 0; p < 3; p++) begin
      m_code[p] = 0; m_ratio[p] = 1; m_cnt[p] = 0;
    end
    sync_cnt = 0;
  endtask

  always @(negedge rst_n) model_reset();

  always @(posedge clk) begin
    cyc++;
    if (rst_n) begin
      if (sync_cnt < 2) sync_cnt++;
      else begin
        for (int p = 0; p < 3; p++) begin
          int wc;
          wc = int'(wdata) & code_mask(p);
          if (m_cnt[p] == m_ratio[p] - 1) begin
            m_ratio[p] = exp_ratio(p, we ? wc : m_code[p]);
            m_cnt[p]   = 0;
          end else m_cnt[p]++;
          if (we) m_code[p] = wc;
        end
      end
    end
  end

  // Compare against the model on every clock, away from the rising edge
  always @(negedge clk) begin
    for (int p = 0; p < 3; p++) begin
      logic et;
      et = (m_cnt[p] == m_ratio[p] - 1);
      checks++;
      if (tick[p] !== et) begin
        errors++;
        $display("FAIL %s profile %0d cycle %0d tick act %0b exp %0b",
                 prof_tags(p), p, cyc, tick[p], et);
      end
      checks++;
      if (rdata[p] !== 8'(m_code[p])) begin
        errors++;
        $display("FAIL R8 R9 profile %0d cycle %0d rdata act %0h exp %0h",
                 p, cyc, rdata[p], m_code[p]);
      end
    end
  end

  task automatic wr(input int v);
    we = 1'b1; wdata = 4'(v);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Watchdog
  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    rst_n = 1'b0; we = 1'b0; wdata = 4'd0;
    idle(3);
    rst_n = 1'b1;
    // R1: strobe every cycle and zero read-back out of reset
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      for (int p = 0; p < 3; p++) begin
        checks++;
        if (tick[p] !== 1'b1 || rdata[p] !== 8'd0) begin
          errors++;
          $display("FAIL R1 profile %0d tick act %0b exp 1 rdata act %0h exp 0",
                   p, tick[p], rdata[p]);
        end
      end
    end

    // R2 R3 R4 R6 R8: every code, written at varying phases
    for (int c = 0; c < 16; c++) begin
      idle((c * 7) % 5);
      wr(c);
      idle(1100);
    end

    // R10: several writes inside one long period
    wr(9); idle(1100);
    wr(2); idle(3); wr(5); idle(2); wr(1);
    idle(1100);

    // R7: write in the same cycle as a strobe of the bus instance
    for (int c = 0; c < 8; c++) begin
      do @(negedge clk); while (tick[0] !== 1'b1);
      wr((c * 5 + 3) % 16);
      idle(40);
    end
    // R7: same for the controller instance
    for (int c = 1; c < 6; c++) begin
      do @(negedge clk); while (tick[1] !== 1'b1);
      wr(c);
      idle(70);
    end
    idle(1100);

    // R1: reset asserted mid-run, then released
    wr(3); idle(10);
    #3 rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(20);
    wr(4); idle(200);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule